// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a byte-wide memory bus and the execute stage of a small processor core. It owns the program counter and, whenever the executing instruction leaves the bus free, reads the next instruction byte from memory and stores it in a short queue. Each stored byte carries the address it was fetched from. Execute takes bytes from the head of the queue with a valid/take handshake.

Execute always has first claim on the bus. In any cycle where it requests a data read or write, that access goes out and prefetching waits. How far the queue runs ahead therefore depends on how often the current instruction touches data memory. When execute changes the flow of control (jump, call, return, restart, interrupt entry), it raises a flush with the new target address. Every queued byte is then dropped and fetching starts again from the target.

The memory is assumed to answer a read in the same cycle the address is presented, so one byte moves per clock. Every bus cycle is labelled with a 2-bit code: `00` idle, `01` instruction read, `10` data read, `11` data write.

Top module: `ifq_prefetch`

## Requirements
- R1: After reset the queue is empty (`byte_valid_o` low). In the first cycle after reset the block issues an instruction read (cycle code `01`) at the reset address, which is 0 by default.
- R2: In a cycle with no flush, no data request and fewer than 3 queued bytes, the block drives the program counter on `bus_addr_o` with cycle code `01`. The byte on `bus_rdata_i` in that cycle enters the queue tagged with that address, and the program counter advances by one.
- R3: When `ex_req_i` is high, the bus cycle carries `ex_addr_i` with code `10` (read, `ex_we_i` low) or `11` (write, `ex_we_i` high, `ex_wdata_i` on `bus_wdata_o`). No instruction read takes place and the program counter does not move.
- R4: When the queue held 3 bytes at the start of a cycle, no instruction read is issued in that cycle (code `00` without a data request). Fetching resumes in the cycle after execute takes a byte.
- R5: Bytes leave the queue in the order they were fetched. While the head is valid and not taken, `byte_o` and `byte_pc_o` hold their values.
- R6: A flush discards all queued bytes, so `byte_valid_o` is low in the following cycle. A take in the flush cycle has no further effect.
- R7: No instruction read is issued in a flush cycle. The first instruction read, at the flush target, comes in the next cycle, and the addresses of later reads count up from there.
- R8: A take while the queue is empty has no effect: the byte fetched in that cycle becomes the head in the next cycle.
- R9: The program counter wraps from the all-ones address to zero, and the bytes on both sides of the wrap carry their own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Control transfer: drop the queue and load a new PC |
| flush_pc_i | input | 24 | New program counter that goes with `flush_i` |
| ex_req_i | input | 1 | Execute requests the bus for a data access |
| ex_we_i | input | 1 | Data access is a write |
| ex_addr_i | input | 24 | Data access address |
| ex_wdata_i | input | 8 | Data write byte |
| bus_addr_o | output | 24 | Memory address of this cycle |
| bus_cyc_o | output | 2 | Cycle code: 00 idle, 01 instruction read, 10 data read, 11 data write |
| bus_wdata_o | output | 8 | Write data (zero unless a data write) |
| bus_rdata_i | input | 8 | Read data returned in the same cycle |
| byte_valid_o | output | 1 | Queue head holds a byte |
| byte_o | output | 8 | Queue head byte |
| byte_pc_o | output | 24 | Fetch address of the head byte |
| byte_take_i | input | 1 | Execute consumes the head byte |

## Verification
The hardest situation to reach from the ports is a full queue meeting a take, followed by a data access and then a flush while bytes are still waiting. It requires holding the take input low until three reads have landed, releasing it for exactly one cycle, and then timing a data request into the cycle where a read would otherwise resume. The directed sequence runs from reset through these steps one cycle at a time. At each step it checks the cycle code and address against a memory model whose contents are a function of the address. A final flush close to the top of the address space brings out the wrap.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    // Bus cycle classification presented to the memory system.
    typedef enum logic [1:0] {
        CYC_IDLE   = 2'b00,
        CYC_IFETCH = 2'b01,
        CYC_DREAD  = 2'b10,
        CYC_DWRITE = 2'b11
    } bus_cyc_e;

endpackage

// File: rtl/ifq_arbiter.sv
module ifq_arbiter
    import ifq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              flush_i,
    input  logic              ex_req_i,
    input  logic              ex_we_i,
    input  logic [ADDR_W-1:0] ex_addr_i,
    input  logic [DATA_W-1:0] ex_wdata_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic              q_full_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output bus_cyc_e          bus_cyc_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              fetch_go_o
);

    // Execute owns the bus first; a flush cycle never fetches, since the
    // PC being driven is already stale.
    always_comb begin
        bus_addr_o  = fetch_pc_i;
        bus_cyc_o   = CYC_IDLE;
        bus_wdata_o = '0;
        fetch_go_o  = 1'b0;
        if (ex_req_i) begin
            bus_addr_o = ex_addr_i;
            if (ex_we_i) begin
                bus_cyc_o   = CYC_DWRITE;
                bus_wdata_o = ex_wdata_i;
            end else begin
                bus_cyc_o = CYC_DREAD;
            end
        end else if (!flush_i && !q_full_i) begin
            bus_cyc_o  = CYC_IFETCH;
            fetch_go_o = 1'b1;
        end
    end

endmodule

// File: rtl/ifq_pc.sv
module ifq_pc #(
    parameter int               ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_pc_i,
    input  logic              fetch_go_i,
    output logic [ADDR_W-1:0] pc_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.pc = flush_pc_i;
        end else if (fetch_go_i) begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

endmodule

// File: rtl/ifq_queue.sv
module ifq_queue #(
    parameter int DEPTH  = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic              full_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic [ADDR_W-1:0] head_addr_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][ADDR_W-1:0] tag;
        logic [PTR_W-1:0]             rd_ptr;
        logic [PTR_W-1:0]             wr_ptr;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic pop_ok;
    logic push_ok;

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop_i && (st_q.cnt != '0);
        push_ok = push_i && (st_q.cnt != FULL);
        if (clear_i) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.cnt    = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_ok && (st_q.wr_ptr == PTR_W'(i))) begin
                    st_d.data[i] = push_data_i;
                    st_d.tag[i]  = push_addr_i;
                end
            end
            if (push_ok) begin
                st_d.wr_ptr = ptr_step(st_q.wr_ptr);
            end
            if (pop_ok) begin
                st_d.rd_ptr = ptr_step(st_q.rd_ptr);
            end
            st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full_o      = (st_q.cnt == FULL);
    assign valid_o     = (st_q.cnt != '0);
    assign head_data_o = st_q.data[st_q.rd_ptr];
    assign head_addr_o = st_q.tag[st_q.rd_ptr];

endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch
    import ifq_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                DATA_W   = 8,
    parameter int                DEPTH    = 3,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] flush_pc_i,
    input  logic              ex_req_i,
    input  logic              ex_we_i,
    input  logic [ADDR_W-1:0] ex_addr_i,
    input  logic [DATA_W-1:0] ex_wdata_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [1:0]        bus_cyc_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_o,
    output logic [ADDR_W-1:0] byte_pc_o,
    input  logic              byte_take_i
);

    logic [ADDR_W-1:0] pc;
    logic              q_full;
    logic              fetch_go;
    bus_cyc_e          cyc;

    ifq_pc #(
        .ADDR_W  (ADDR_W),
        .RESET_PC(RESET_PC)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .flush_pc_i(flush_pc_i),
        .fetch_go_i(fetch_go),
        .pc_o      (pc)
    );

    ifq_arbiter #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arb (
        .flush_i    (flush_i),
        .ex_req_i   (ex_req_i),
        .ex_we_i    (ex_we_i),
        .ex_addr_i  (ex_addr_i),
        .ex_wdata_i (ex_wdata_i),
        .fetch_pc_i (pc),
        .q_full_i   (q_full),
        .bus_addr_o (bus_addr_o),
        .bus_cyc_o  (cyc),
        .bus_wdata_o(bus_wdata_o),
        .fetch_go_o (fetch_go)
    );

    ifq_queue #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (flush_i),
        .push_i     (fetch_go),
        .push_data_i(bus_rdata_i),
        .push_addr_i(pc),
        .pop_i      (byte_take_i),
        .full_o     (q_full),
        .valid_o    (byte_valid_o),
        .head_data_o(byte_o),
        .head_addr_o(byte_pc_o)
    );

    assign bus_cyc_o = cyc;

endmodule

// File: rtl/ifq_checks.sv
module ifq_checks #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush_i,
    input logic [ADDR_W-1:0] flush_pc_i,
    input logic              ex_req_i,
    input logic              ex_we_i,
    input logic [ADDR_W-1:0] ex_addr_i,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [1:0]        bus_cyc_o,
    input logic              byte_valid_o,
    input logic [DATA_W-1:0] byte_o,
    input logic [ADDR_W-1:0] byte_pc_o,
    input logic              byte_take_i
);

    // R3
    data_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_req_i |-> (bus_addr_o == ex_addr_i) && (bus_cyc_o == (ex_we_i ? 2'b11 : 2'b10)));

    // R7
    flush_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (bus_cyc_o != 2'b01));

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !byte_valid_o);

    // R7
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (ex_req_i || flush_i ||
                     ((bus_cyc_o == 2'b01) && (bus_addr_o == $past(flush_pc_i)))));

    // R2
    seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cyc_o == 2'b01) && !flush_i) |=>
            ((bus_cyc_o != 2'b01) || (bus_addr_o == ADDR_W'($past(bus_addr_o) + 1'b1))));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && !byte_take_i && !flush_i) |=>
            (byte_valid_o && $stable(byte_o) && $stable(byte_pc_o)));

endmodule

bind ifq_prefetch ifq_checks #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_ifq_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .flush_pc_i  (flush_pc_i),
    .ex_req_i    (ex_req_i),
    .ex_we_i     (ex_we_i),
    .ex_addr_i   (ex_addr_i),
    .bus_addr_o  (bus_addr_o),
    .bus_cyc_o   (bus_cyc_o),
    .byte_valid_o(byte_valid_o),
    .byte_o      (byte_o),
    .byte_pc_o   (byte_pc_o),
    .byte_take_i (byte_take_i)
);

// File: tb/test_ifq_prefetch.sv
`timescale 1ns/1ps
module test_ifq_prefetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush;
    logic [23:0] flush_pc;
    logic        ex_req;
    logic        ex_we;
    logic [23:0] ex_addr;
    logic [7:0]  ex_wdata;
    logic [23:0] bus_addr;
    logic [1:0]  bus_cyc;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bvalid;
    logic [7:0]  bbyte;
    logic [23:0] bpc;
    logic        take;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign bus_rdata = mem_f(bus_addr);

    ifq_prefetch i_ifq_prefetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .flush_pc_i  (flush_pc),
        .ex_req_i    (ex_req),
        .ex_we_i     (ex_we),
        .ex_addr_i   (ex_addr),
        .ex_wdata_i  (ex_wdata),
        .bus_addr_o  (bus_addr),
        .bus_cyc_o   (bus_cyc),
        .bus_wdata_o (bus_wdata),
        .bus_rdata_i (bus_rdata),
        .byte_valid_o(bvalid),
        .byte_o      (bbyte),
        .byte_pc_o   (bpc),
        .byte_take_i (take)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance to the next cycle: inputs are changed just after a falling edge.
    task automatic next_cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        flush = 1'b0; flush_pc = '0; ex_req = 1'b0; ex_we = 1'b0;
        ex_addr = '0; ex_wdata = '0; take = 1'b0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "valid after reset", 32'(bvalid), 32'd0);
        chk("R1", "first cycle code", 32'(bus_cyc), 32'd1);
        chk("R1", "first address", 32'(bus_addr), 32'h0);
    endtask

    task automatic t_fill();
        next_cyc();
        chk("R2", "second fetch addr", 32'(bus_addr), 32'h1);
        chk("R2", "head byte", 32'(bbyte), 32'(mem_f(24'h0)));
        chk("R2", "head tag", 32'(bpc), 32'h0);
        next_cyc();
        chk("R2", "third fetch code", 32'(bus_cyc), 32'd1);
        next_cyc();
        take = 1'b1;
        #1;
        chk("R4", "full queue blocks fetch", 32'(bus_cyc), 32'd0);
        next_cyc();
        take = 1'b0;
        #1;
        chk("R4", "fetch resumes after take", 32'(bus_cyc), 32'd1);
        chk("R4", "resumed address", 32'(bus_addr), 32'h3);
        chk("R5", "second byte tag", 32'(bpc), 32'h1);
        chk("R5", "second byte data", 32'(bbyte), 32'(mem_f(24'h1)));
    endtask

    task automatic t_data_priority();
        next_cyc();
        take = 1'b1;
        next_cyc();
        take = 1'b0;
        ex_req = 1'b1; ex_we = 1'b0; ex_addr = 24'h004000;
        #1;
        chk("R3", "data read code", 32'(bus_cyc), 32'd2);
        chk("R3", "data read address", 32'(bus_addr), 32'h4000);
        next_cyc();
        ex_we = 1'b1; ex_addr = 24'h004001; ex_wdata = 8'h77;
        #1;
        chk("R3", "data write code", 32'(bus_cyc), 32'd3);
        chk("R3", "data write address", 32'(bus_addr), 32'h4001);
        chk("R3", "write data", 32'(bus_wdata), 32'h77);
        next_cyc();
        ex_req = 1'b0; ex_we = 1'b0;
        #1;
        chk("R3", "pc held across data cycles", 32'(bus_addr), 32'h4);
        chk("R3", "fetch after data cycles", 32'(bus_cyc), 32'd1);
        chk("R5", "head after two takes", 32'(bpc), 32'h2);
    endtask

    task automatic t_flush();
        next_cyc();
        flush = 1'b1; flush_pc = 24'h002000; take = 1'b1;
        #1;
        chk("R7", "no fetch in flush cycle", 32'(bus_cyc), 32'd0);
        next_cyc();
        flush = 1'b0; take = 1'b1;
        #1;
        chk("R6", "queue empty after flush", 32'(bvalid), 32'd0);
        chk("R7", "restart code", 32'(bus_cyc), 32'd1);
        chk("R7", "restart address", 32'(bus_addr), 32'h2000);
        next_cyc();
        take = 1'b0;
        #1;
        chk("R8", "take on empty ignored", 32'(bvalid), 32'd1);
        chk("R8", "head tag after empty take", 32'(bpc), 32'h2000);
        chk("R8", "head data after empty take", 32'(bbyte), 32'(mem_f(24'h2000)));
        chk("R7", "address after restart", 32'(bus_addr), 32'h2001);
    endtask

    task automatic t_wrap();
        next_cyc();
        flush = 1'b1; flush_pc = 24'hFFFFFE;
        next_cyc();
        flush = 1'b0;
        #1;
        chk("R9", "fetch below top", 32'(bus_addr), 32'hFFFFFE);
        next_cyc();
        chk("R9", "fetch at top", 32'(bus_addr), 32'hFFFFFF);
        next_cyc();
        chk("R9", "fetch wraps to zero", 32'(bus_addr), 32'h0);
        next_cyc();
        take = 1'b1;
        #1;
        chk("R9", "tag below top", 32'(bpc), 32'hFFFFFE);
        next_cyc();
        chk("R9", "tag at top", 32'(bpc), 32'hFFFFFF);
        next_cyc();
        chk("R9", "tag after wrap", 32'(bpc), 32'h0);
        chk("R9", "data after wrap", 32'(bbyte), 32'(mem_f(24'h0)));
        take = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_data_priority();
        t_flush();
        t_wrap();
        next_cyc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule